// File: doc/BRIEF.md
# Synchronizable PWM Period Timebase

This block produces the switching-period timebase for a fixed-frequency PWM controller. A counter advances on every system clock from zero to one less than a configured period. It then returns to zero and raises a one-cycle period-start strobe. The running count is exposed so that a duty comparator elsewhere can compare it against a duty word. The period is given in system-clock counts, so the free-running switching frequency is the system clock divided by `periodCfg`.

The block also drives a shared synchronization line. When no other unit leads, the block is master. It drives a fixed-width pulse onto the line starting half a period after each period start. Every rising edge seen on the line is passed through a flop synchronizer and an edge detector. If that edge does not come from the block's own pulse, the block restarts its period on it with no phase offset. It then becomes slave and stops driving the line. Two units wired to one line therefore settle with the faster one leading and the other switching at its rate, half a period behind.

The slave flag drops again as soon as a whole local period ends without an external edge. The block then resumes free-running and emits its own pulse.

Top module: `syncPwmTimebase`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rampCount is 0, and periodStart, syncOut and isSlave are 0.
- R2: With no accepted external edge, rampCount counts 0,1,...,P-1 and then returns to 0, where P is the effective period. periodStart is 1 exactly in the cycles in which rampCount has just been loaded with 0 by a wrap or a restart.
- R3: The effective period P is periodCfg, but any value below 4 is treated as 4. If periodCfg is lowered while rampCount is already at or beyond the new P-1, the count wraps to 0 on the next clock.
- R4: While the block is master, syncOut is 1 for exactly PULSE_W (default 11) consecutive cycles. The pulse starts in the cycle in which rampCount is P>>1, and syncOut is 0 at all other times.
- R5: A rising edge on syncIn is accepted when syncIn is sampled 0 at one clock edge and 1 at the next clock edge k. After edge k+2, rampCount is 0 and periodStart is 1 (two synchronizer flops, one edge register).
- R6: isSlave becomes 1 with each accepted external edge. It returns to 0 when a period ends by wrap without an accepted edge in that cycle. While isSlave is 1, syncOut stays 0.
- R7: After the block starts its own pulse, rising edges on syncIn are ignored for PULSE_W+3 cycles. This covers the echo of the block's own pulse through the synchronizer.
- R8: An accepted edge in the same cycle as the local wrap gives a single period start: rampCount goes to 0 once and to 1 in the following cycle.
- R9: A level held high on syncIn restarts the period only once, on its rising edge; the period then runs free while the level stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodCfg | input | CNT_W | Switching period in system-clock counts (minimum 4) |
| syncIn | input | 1 | Level of the shared synchronization line, asynchronous |
| syncOut | output | 1 | Drive-high request for the shared line during the master pulse |
| periodStart | output | 1 | One-cycle strobe at each period start |
| rampCount | output | CNT_W | Current position in the period, for duty comparison |
| isSlave | output | 1 | 1 while the period follows an external sync edge |

## Verification
The reference model is first run free with the block's own pulse looped back onto syncIn. This separates a correctly masked echo from one that would restart the period. External pulse trains faster than the local period, and trains equal to it, show takeover with zero phase. They also show that an edge coinciding with the wrap yields one start instead of two. Removing the external train shows the return to master. A long held-high level, a period below the minimum and a period lowered mid-count probe edge-only triggering, the clamp and the out-of-range wrap.

// File: rtl/pwmTbPkg.sv
package pwmTbPkg;

  // Strobes from the control to the datapath, valid for the current cycle
  typedef struct packed {
    logic restart;  // load the period counter with zero this clock
    logic fire;     // start the master sync pulse this clock
  } tbStrobe_t;

endpackage

// File: rtl/tbEdgeSync.sv
module tbEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic riseDet
);

  // stg[STAGES-1] is the synchronized level, stg[STAGES] its previous value
  logic [STAGES:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= '0;
    else       stg <= {stg[STAGES-1:0], lineIn};
  end

  assign riseDet = stg[STAGES-1] & ~stg[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    riseDet |=> !riseDet); // R9

endmodule

// File: rtl/tbCtrl.sv
module tbCtrl
  import pwmTbPkg::*;
#(
  parameter int PULSE_W = 11,
  parameter int STAGES  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      riseDet,
  input  logic      atEnd,
  input  logic      hitsHalf,
  output tbStrobe_t strb,
  output logic      slaveQ
);

  // own pulse echoes back after STAGES+1 flops; mask for the pulse plus that
  localparam int GUARD_LEN = PULSE_W + STAGES + 1;
  localparam int GW        = $clog2(GUARD_LEN + 1);

  logic [GW-1:0] guardCnt;
  logic          accept;

  assign accept       = riseDet && (guardCnt == '0);
  assign strb.restart = accept | atEnd;
  assign strb.fire    = hitsHalf & ~strb.restart & ~slaveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveQ <= 1'b0;
    end else if (accept) begin
      slaveQ <= 1'b1;
    end else if (atEnd) begin
      slaveQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      guardCnt <= '0;
    end else if (strb.fire) begin
      guardCnt <= GW'(GUARD_LEN);
    end else if (guardCnt != '0) begin
      guardCnt <= guardCnt - 1'b1;
    end
  end

  AST_SLAVE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slaveQ) |-> $past(riseDet)); // R6

  AST_FIRE_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> !slaveQ); // R4

endmodule

// File: rtl/tbDatapath.sv
module tbDatapath
  import pwmTbPkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PULSE_W    = 11,
  parameter int MIN_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  tbStrobe_t        strb,
  output logic [CNT_W-1:0] rampCount,
  output logic             periodStart,
  output logic             syncOut,
  output logic             atEnd,
  output logic             hitsHalf
);

  localparam int PW_W = $clog2(PULSE_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effPeriod;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] halfPt;
  logic [CNT_W:0]   cntInc;
  logic             startQ;
  logic [PW_W-1:0]  pulseCnt;

  assign effPeriod = (periodCfg < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : periodCfg;
  assign lastIdx   = effPeriod - 1'b1;
  assign halfPt    = effPeriod >> 1;
  assign cntInc    = {1'b0, cnt} + 1'b1;
  assign atEnd     = (cnt >= lastIdx);
  assign hitsHalf  = (cntInc == {1'b0, halfPt});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      startQ <= 1'b0;
    end else begin
      startQ <= strb.restart;
      cnt    <= strb.restart ? '0 : cntInc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.fire) begin
      pulseCnt <= PW_W'(PULSE_W);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign rampCount   = cnt;
  assign periodStart = startQ;
  assign syncOut     = (pulseCnt != '0);

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cnt == '0)); // R2

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> (rampCount == '0)); // R2

  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> syncOut); // R4

endmodule

// File: rtl/syncPwmTimebase.sv
module syncPwmTimebase
  import pwmTbPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PULSE_W     = 11,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             syncIn,
  output logic             syncOut,
  output logic             periodStart,
  output logic [CNT_W-1:0] rampCount,
  output logic             isSlave
);

  tbStrobe_t strb;
  logic      riseDet;
  logic      atEnd;
  logic      hitsHalf;

  tbEdgeSync #(.STAGES(SYNC_STAGES)) uEdge (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (syncIn),
    .riseDet (riseDet)
  );

  tbCtrl #(.PULSE_W(PULSE_W), .STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .riseDet  (riseDet),
    .atEnd    (atEnd),
    .hitsHalf (hitsHalf),
    .strb     (strb),
    .slaveQ   (isSlave)
  );

  tbDatapath #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .MIN_PERIOD(MIN_PERIOD)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .periodCfg   (periodCfg),
    .strb        (strb),
    .rampCount   (rampCount),
    .periodStart (periodStart),
    .syncOut     (syncOut),
    .atEnd       (atEnd),
    .hitsHalf    (hitsHalf)
  );

  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    isSlave |-> !syncOut); // R6

endmodule

// File: tb/sim_syncPwmTimebase.sv
module sim_syncPwmTimebase;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PW         = 11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] periodCfg = 16'd20;
  logic             ext = 1'b0;
  logic             loopOn = 1'b1;
  logic             syncIn;
  logic             syncOut;
  logic             periodStart;
  logic [CNT_W-1:0] rampCount;
  logic             isSlave;

  assign syncIn = ext | (loopOn & syncOut);

  syncPwmTimebase u0 (
    .clk         (clk),
    .rstN        (rstN),
    .periodCfg   (periodCfg),
    .syncIn      (syncIn),
    .syncOut     (syncOut),
    .periodStart (periodStart),
    .rampCount   (rampCount),
    .isSlave     (isSlave)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vecs = 0;
  int    misses = 0;
  string phaseTag = "R1";
  bit    done = 1'b0;
  bit    cmpOn = 1'b0;
  bit    r8Watch = 1'b0;
  bit    prevStart = 1'b0;

  // behavioural reference state
  int mCnt = 0, mPulse = 0, mGuard = 0;
  bit mStart = 0, mSlave = 0;
  bit sq[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPulse = 0; mGuard = 0; mStart = 0; mSlave = 0;
      sq = '{0, 0, 0};
    end else begin
      bit line, rise, acc, wrapEnd, rst, fire;
      int eff, half;
      line    = ext | (loopOn && mPulse > 0);
      rise    = sq[1] && !sq[2];
      acc     = rise && (mGuard == 0);
      eff     = (periodCfg < 4) ? 4 : int'(periodCfg);
      half    = eff / 2;
      wrapEnd = (mCnt >= eff - 1);
      rst     = acc || wrapEnd;
      fire    = !rst && (mCnt + 1 == half) && !mSlave;
      if (acc) mSlave = 1; else if (wrapEnd) mSlave = 0;
      if (fire) mPulse = PW; else if (mPulse > 0) mPulse--;
      if (fire) mGuard = PW + 3; else if (mGuard > 0) mGuard--;
      mStart = rst;
      mCnt   = rst ? 0 : mCnt + 1;
      void'(sq.pop_back());
      sq.push_front(line);
    end
  end

  task automatic check(input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", phaseTag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      check("rampCount",   int'(rampCount),   mCnt);
      check("periodStart", int'(periodStart), int'(mStart));
      check("syncOut",     int'(syncOut),     int'(mPulse > 0));
      check("isSlave",     int'(isSlave),     int'(mSlave));
      if (r8Watch && periodStart) begin
        vecs++;
        if (prevStart) begin
          misses++;
          $display("FAIL R8 back-to-back start act=1 exp=0 t=%0t", $time);
        end
      end
      prevStart = periodStart;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic extTrain(input int count, input int hi, input int gap);
    for (int i = 0; i < count; i++) begin
      ext = 1'b1; idle(hi);
      ext = 1'b0; idle(gap);
    end
  endtask

  initial begin
    idle(3);
    phaseTag = "R1";
    check("reset rampCount",   int'(rampCount),   0);
    check("reset periodStart", int'(periodStart), 0);
    check("reset syncOut",     int'(syncOut),     0);
    check("reset isSlave",     int'(isSlave),     0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    idle(1);
    check("post-reset rampCount", int'(rampCount), 1);

    phaseTag = "R2 R4 R7 free-run with own echo looped";
    idle(120);

    phaseTag = "R5 R6 faster external train";
    extTrain(8, 3, 11);
    check("R6 slave after faster train", int'(isSlave), 1);

    phaseTag = "R8 R5 equal-rate train";
    r8Watch = 1'b1;
    extTrain(6, 2, 18);
    r8Watch = 1'b0;

    phaseTag = "R6 R4 train removed";
    idle(60);
    check("R6 master after train stops", int'(isSlave), 0);

    phaseTag = "R9 held-high line";
    ext = 1'b1; idle(90);
    ext = 1'b0; idle(30);

    phaseTag = "R3 period below minimum";
    periodCfg = 16'd2; idle(30);

    phaseTag = "R3 period lowered mid-count";
    periodCfg = 16'd40; idle(35);
    periodCfg = 16'd10; idle(30);

    phaseTag = "R7 R5 external edge near own pulse";
    periodCfg = 16'd30;
    idle(16);
    extTrain(1, 2, 6);
    extTrain(1, 2, 60);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, misses);
      $finish;
    end
  end

endmodule